// File: doc/BRIEF.md
# Refresh-Triggered Driver Strength Calibrator

This block keeps the strength code of an open-drain output driver whose pull-down is split into binary-weighted legs. Each bit of the code enables one leg, so the pull-down strength is proportional to the code value. The block needs no code or command from outside the chip. Each rising edge of the memory's internal auto-refresh request opens a fixed-length calibration window. Inside the window, the block reads one comparator bit. The comparator reports whether the driver's low output level sits above or below its reference. The block nudges a private working code one count at a time in the direction that closes the gap, which forms a negative feedback loop around the analog path.

The code that actually drives the legs is a separate live register. It is loaded from the working code in a single clock when the window closes, and that clock is marked by a one-cycle done pulse. The live code therefore never moves while a window is open or while the block is idle. The block also detects when the loop has settled: once the comparator's answer flips on consecutive steps, the working code is frozen for the rest of that window.

Top module: `drv_cal_ctrl`

## Requirements
- R1: After reset, the live code drv_code is 32 (mid-scale of the 6-bit range) and the working code is also 32. busy and done are both 0.
- R2: A rising edge on refresh_req while busy is 0 starts a window. busy goes high on the next cycle and stays high for exactly WIN_LEN (default 64) cycles.
- R3: A rising edge on refresh_req while busy is 1 has no effect. The window still closes WIN_LEN cycles after it opened, and the committed code is unchanged by that edge.
- R4: The working code can step only on window cycles STEP_DIV-1, 2*STEP_DIV-1, and so on, counting from 0 at the first busy cycle. Window cycles are numbered from 0 at the first busy cycle, and no step happens on the last window cycle (15 steps per window at the defaults). On a step, cmp_high=1 adds one and cmp_high=0 subtracts one.
- R5: The working code saturates at the rails. An up step at 63 leaves it at 63, and a down step at 0 leaves it at 0.
- R6: Once the comparator direction has reversed on two consecutive steps (three steps that alternate, such as up, down, up), the third of those steps is applied and the working code is then held until the window closes. The settling state is cleared when each new window opens.
- R7: drv_code changes only in the cycle in which done is high. It is constant for the whole time busy is high.
- R8: done is a single-cycle pulse. It is high in the first cycle after the last busy cycle, and drv_code shows the committed working code in that same cycle.
- R9: While no window is open, cmp_high has no effect. drv_code keeps its value and the next window starts stepping from the last committed code.
- R10: Asserting rst during a window aborts it. busy and done drop, and both codes return to 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| refresh_req | input | 1 | Internal auto-refresh request; its rising edge opens a window |
| cmp_high | input | 1 | Comparator: 1 = low output level above reference, 0 = below |
| drv_code | output | CODE_W | Live leg-enable code to the output driver |
| busy | output | 1 | High while a calibration window is open |
| done | output | 1 | One-cycle pulse when the working code is committed |

## Verification
The bench builds the block with its default parameters: a 6-bit code, a 64-cycle window and one step every 4 cycles, with settling declared after three alternating steps. A window at these settings gives 15 steps. A constant comparator therefore moves the code by 15 per window, so a few chained windows starting from 32 reach both rails and show saturation. Per-step comparator patterns, aligned to the known step cycles, show a settled window freezing partway through and a window that never settles because its reversals are broken up by repeated directions. Directed cases cover a second refresh edge inside a window, comparator activity while idle, and a reset in the middle of a window.

// File: rtl/drv_cal_pkg.sv
package drv_cal_pkg;

  // Per-cycle events produced by the window sequencer.
  typedef struct packed {
    logic open;   // window starts on the next cycle
    logic step;   // a comparator sample may move the working code
    logic close;  // last window cycle, commit on this edge
  } cal_tick_t;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } step_dir_e;

endpackage

// File: rtl/drv_cal_window.sv
module drv_cal_window
  import drv_cal_pkg::*;
#(
  parameter int WIN_LEN  = 64,
  parameter int STEP_DIV = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      refresh_req,
  output logic      busy,
  output cal_tick_t tick
);

  localparam int CNT_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIN_LEN - 1);

  logic             req_q;
  logic             busy_q;
  logic [CNT_W-1:0] win_cnt;
  logic             rise;
  logic             pace_hit;
  logic             last_cyc;

  assign rise     = refresh_req & ~req_q;
  assign last_cyc = busy_q & (win_cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
    end else begin
      req_q <= refresh_req;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      win_cnt <= '0;
    end else if (rise && !busy_q) begin
      busy_q  <= 1'b1;
      win_cnt <= '0;
    end else if (busy_q) begin
      if (win_cnt == CNT_LAST) begin
        busy_q <= 1'b0;
      end
      win_cnt <= win_cnt + 1'b1;
    end
  end

  // Step pacing: one opportunity every STEP_DIV window cycles.
  generate
    if (STEP_DIV <= 1) begin : g_pace_every
      assign pace_hit = busy_q;
    end else begin : g_pace_div
      localparam int PC_W = $clog2(STEP_DIV);
      localparam logic [PC_W-1:0] PC_LAST = PC_W'(STEP_DIV - 1);
      logic [PC_W-1:0] pace_cnt;

      always_ff @(posedge clk) begin
        if (rst) begin
          pace_cnt <= '0;
        end else if (rise && !busy_q) begin
          pace_cnt <= '0;
        end else if (busy_q) begin
          pace_cnt <= (pace_cnt == PC_LAST) ? '0 : pace_cnt + 1'b1;
        end
      end

      assign pace_hit = busy_q & (pace_cnt == PC_LAST);
    end
  endgenerate

  assign busy       = busy_q;
  assign tick.open  = rise & ~busy_q;
  assign tick.step  = pace_hit & ~last_cyc;
  assign tick.close = last_cyc;

endmodule

// File: rtl/drv_cal_settle.sv
module drv_cal_settle
  import drv_cal_pkg::*;
#(
  parameter int CONV_STEPS = 3
) (
  input  logic      clk,
  input  logic      rst,
  input  cal_tick_t tick,
  input  logic      cmp_high,
  output logic      step_en
);

  localparam int REV_NEED = (CONV_STEPS > 1) ? CONV_STEPS - 1 : 1;
  localparam int REV_W    = $clog2(REV_NEED + 1);
  localparam logic [REV_W-1:0] REV_LAST = REV_W'(REV_NEED);

  step_dir_e        prev_dir;
  logic             have_prev;
  logic             held;
  logic [REV_W-1:0] rev_cnt;
  step_dir_e        cur_dir;
  logic             reversal;

  assign cur_dir  = cmp_high ? DIR_UP : DIR_DOWN;
  assign reversal = have_prev & (cur_dir != prev_dir);
  assign step_en  = tick.step & ~held;

  always_ff @(posedge clk) begin
    if (rst || tick.open) begin
      prev_dir  <= DIR_DOWN;
      have_prev <= 1'b0;
      held      <= 1'b0;
      rev_cnt   <= '0;
    end else if (step_en) begin
      prev_dir  <= cur_dir;
      have_prev <= 1'b1;
      if (reversal) begin
        rev_cnt <= rev_cnt + 1'b1;
        if (rev_cnt + 1'b1 == REV_LAST) begin
          held <= 1'b1;
        end
      end else begin
        rev_cnt <= '0;
      end
    end
  end

endmodule

// File: rtl/drv_cal_code.sv
module drv_cal_code
  import drv_cal_pkg::*;
#(
  parameter int CODE_W     = 6,
  parameter int RESET_CODE = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  cal_tick_t         tick,
  input  logic              step_en,
  input  logic              cmp_high,
  output logic [CODE_W-1:0] work_code,
  output logic [CODE_W-1:0] live_code
);

  localparam logic [CODE_W-1:0] CODE_MAX  = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_MIN  = '0;
  localparam logic [CODE_W-1:0] CODE_INIT = CODE_W'(RESET_CODE);

  logic [CODE_W-1:0] work_q;
  logic [CODE_W-1:0] live_q;
  logic [CODE_W-1:0] work_nxt;

  always_comb begin
    work_nxt = work_q;
    if (step_en) begin
      if (cmp_high) begin
        if (work_q != CODE_MAX) work_nxt = work_q + 1'b1;
      end else begin
        if (work_q != CODE_MIN) work_nxt = work_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q <= CODE_INIT;
    end else begin
      work_q <= work_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= CODE_INIT;
    end else if (tick.close) begin
      live_q <= work_q;
    end
  end

  assign work_code = work_q;
  assign live_code = live_q;

endmodule

// File: rtl/drv_cal_ctrl.sv
module drv_cal_ctrl
  import drv_cal_pkg::*;
#(
  parameter int CODE_W     = 6,
  parameter int RESET_CODE = 32,
  parameter int WIN_LEN    = 64,
  parameter int STEP_DIV   = 4,
  parameter int CONV_STEPS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              refresh_req,
  input  logic              cmp_high,
  output logic [CODE_W-1:0] drv_code,
  output logic              busy,
  output logic              done
);

  cal_tick_t         tick;
  logic              step_en;
  logic [CODE_W-1:0] work_code;
  logic              done_q;

  drv_cal_window #(
    .WIN_LEN  (WIN_LEN),
    .STEP_DIV (STEP_DIV)
  ) u_window (
    .clk         (clk),
    .rst         (rst),
    .refresh_req (refresh_req),
    .busy        (busy),
    .tick        (tick)
  );

  drv_cal_settle #(
    .CONV_STEPS (CONV_STEPS)
  ) u_settle (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .cmp_high (cmp_high),
    .step_en  (step_en)
  );

  drv_cal_code #(
    .CODE_W     (CODE_W),
    .RESET_CODE (RESET_CODE)
  ) u_code (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .step_en   (step_en),
    .cmp_high  (cmp_high),
    .work_code (work_code),
    .live_code (drv_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
    end else begin
      done_q <= tick.close;
    end
  end

  assign done = done_q;

endmodule

// File: rtl/drv_cal_ctrl_chk.sv
module drv_cal_ctrl_chk #(
  parameter int CODE_W  = 6,
  parameter int WIN_LEN = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic [CODE_W-1:0] drv_code,
  input logic [CODE_W-1:0] work_code
);

  localparam int BC_W = $clog2(WIN_LEN + 1) + 1;

  logic [BC_W-1:0] busy_len;

  always_ff @(posedge clk) begin
    if (rst || !busy) begin
      busy_len <= '0;
    end else begin
      busy_len <= busy_len + 1'b1;
    end
  end

  // R2: a window never exceeds WIN_LEN cycles
  assert_win_bound_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_len < BC_W'(WIN_LEN)));

  // R2 / R3: a window closes after exactly WIN_LEN cycles
  assert_win_exact_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_len == BC_W'(WIN_LEN)));

  // R7: live code moves only with done
  assert_live_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(drv_code));

  // R8: done is a one-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: done coincides with the end of a window
  assert_done_close_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> $fell(busy));

  // R4: working code moves by at most one per cycle inside a window
  assert_unit_step_R4: assert property (@(posedge clk) disable iff (rst)
    busy |=> ((work_code == $past(work_code)) ||
              ({1'b0, work_code} == {1'b0, $past(work_code)} + (CODE_W+1)'(1)) ||
              ({1'b0, $past(work_code)} == {1'b0, work_code} + (CODE_W+1)'(1))));

  // R9: working code is frozen while idle
  assert_idle_work_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(work_code));

endmodule

bind drv_cal_ctrl drv_cal_ctrl_chk #(
  .CODE_W  (CODE_W),
  .WIN_LEN (WIN_LEN)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .drv_code  (drv_code),
  .work_code (work_code)
);

// File: tb/sim_drv_cal_ctrl.sv
`timescale 1ns/1ps
module sim_drv_cal_ctrl;

  localparam int CODE_W  = 6;
  localparam int WIN_LEN = 64;
  localparam int NVEC    = 10;

  // {comparator bit per step j (bit j), expected committed code}
  localparam logic [21:0] VEC [NVEC] = '{
    {16'hFFFF, 6'd47},  // R4 up from 32
    {16'hFFFF, 6'd62},  // R4
    {16'hFFFF, 6'd63},  // R5 top rail
    {16'h0000, 6'd48},  // R4 down
    {16'h0000, 6'd33},
    {16'h0000, 6'd18},
    {16'h0000, 6'd3},
    {16'h0000, 6'd0},   // R5 bottom rail
    {16'h555F, 6'd5},   // R6 settles after up,down,up
    {16'h9999, 6'd4}    // R6 cleared per window, never settles
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              refresh_req = 1'b0;
  logic              cmp_high = 1'b0;
  logic [CODE_W-1:0] drv_code;
  logic              busy;
  logic              done;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  drv_cal_ctrl u0 (
    .clk         (clk),
    .rst         (rst),
    .refresh_req (refresh_req),
    .cmp_high    (cmp_high),
    .drv_code    (drv_code),
    .busy        (busy),
    .done        (done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One window; cmp per step from pat. Optional second edge mid-window.
  task automatic run_window(input logic [15:0] pat, input int exp,
                            input bit extra_edge, input string tag);
    int held_code = drv_code;
    int busy_bad = 0;
    int hold_bad = 0;
    int done_bad = 0;
    @(negedge clk);
    refresh_req = 1'b1;
    @(posedge clk);
    for (int c = 1; c <= WIN_LEN; c++) begin
      @(negedge clk);
      cmp_high = pat[(c-1)/4];
      if (c == 2) refresh_req = 1'b0;
      if (extra_edge && c == 20) refresh_req = 1'b1;
      if (extra_edge && c == 22) refresh_req = 1'b0;
      if (busy !== 1'b1) busy_bad++;
      if (int'(drv_code) != held_code) hold_bad++;
      if (done !== 1'b0) done_bad++;
      @(posedge clk);
    end
    @(negedge clk);
    chk({tag, " R2 busy held whole window"}, busy_bad, 0);
    chk({tag, " R7 live code held in window"}, hold_bad, 0);
    chk({tag, " R8 no early done"}, done_bad, 0);
    chk({tag, " R2 busy low after window"}, int'(busy), 0);
    chk({tag, " R8 done at close"}, int'(done), 1);
    chk({tag, " R8 committed code"}, int'(drv_code), exp);
    @(negedge clk);
    chk({tag, " R8 done one cycle"}, int'(done), 0);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 drv_code", int'(drv_code), 32);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);

    // Vector table walk
    for (int i = 0; i < NVEC; i++) begin
      run_window(VEC[i][21:6], int'(VEC[i][5:0]), 1'b0, $sformatf("vec%0d", i));
    end

    // R3: second edge in window ignored, 4 -> 19
    run_window(16'hFFFF, 19, 1'b1, "R3 extra edge");
    repeat (5) @(negedge clk);
    chk("R3 no second window", int'(busy), 0);

    // R9: comparator toggled while idle
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      cmp_high = ~cmp_high;
    end
    @(negedge clk);
    chk("R9 idle code kept", int'(drv_code), 19);
    chk("R9 idle busy", int'(busy), 0);
    run_window(16'h0000, 4, 1'b0, "R9 resume from committed");

    // R10: reset during a window
    @(negedge clk);
    refresh_req = 1'b1;
    cmp_high = 1'b1;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      refresh_req = 1'b0;
    end
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R10 code after abort", int'(drv_code), 32);
    chk("R10 busy after abort", int'(busy), 0);
    chk("R10 done after abort", int'(done), 0);
    run_window(16'h0000, 17, 1'b0, "R10 work code reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule